// File: doc/BRIEF.md
# DMA Interrupt Flag and Enable Register

This block is a single 32-bit control and status word that gathers the completion events of up to seven DMA channels into one interrupt toward the main interrupt controller. Software writes the word to set per-channel enables, a master enable, a bus-error flag and six spare read/write bits. Each channel reports completion with a one-cycle strobe. A strobe from a channel whose enable is set raises that channel's flag. Software acknowledges a flag by writing a 1 to it.

From the current fields the block derives an interrupt condition. Bit 31 mirrors that condition. A one-cycle pulse leaves the block only when bit 31 goes from 0 to 1, so the interrupt controller sees one event per transition and not one per completion. Writes and strobes take effect at the next rising clock edge, and the new word and the pulse appear together.

Top module: `dma_irq_ctl`

## Requirements
- R1: After reset the word reads 0x00000000 and `irq_pulse` is 0.
- R2: A write copies bits 0-5, 15 and 16-23 from `wr_data`. Bits 6-14 always read 0, and the written value of bit 31 is ignored.
- R3: Writing 1 to a flag bit 24+n clears that flag. Writing 0 to it leaves the flag unchanged.
- R4: A strobe on `done_stb[n]` sets flag bit 24+n only when enable bit 16+n is set at that edge. A strobe on a disabled channel changes nothing.
- R5: The condition is (master enable bit 23 AND any of flags 24-30) OR bus-error bit 15. Bit 31 reads 1 exactly when the condition holds, and reads 0 after any write that leaves the condition false.
- R6: `irq_pulse` is 1 only in the cycle in which bit 31 changes from 0 to 1. Further strobes or writes that keep the condition true do not pulse again.
- R7: If a strobe and a clearing write hit the same flag in the same cycle, the flag ends set. The strobe is gated by the enable held before that write.
- R8: `irq_pulse` never stays high for two cycles in a row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 32 | Word written when `wr_en` is 1 |
| done_stb | input | 7 | Per-channel completion strobes |
| rd_data | output | 32 | Current register word |
| irq_pulse | output | 1 | One-cycle interrupt toward the main controller |

## Verification
A processor write and a channel completion strobe can land in the same clock cycle. That case decides whether an event is lost or whether the stale enable or the new one gates it. The bench drives a clearing write and a strobe on the same channel together, once with the master enable kept on and once with the write also turning every enable off. It checks that the flag survives both times, and that the pulse and bit 31 follow the condition as rebuilt from the surviving fields.

// File: rtl/dma_irq_pkg.sv
package dma_irq_pkg;
    localparam int CH_MAX   = 7;
    localparam int WORD_W   = 32;
    localparam int AUX_W    = 6;
    localparam int BERR_POS = 15;
    localparam int EN_LSB   = 16;
    localparam int MEN_POS  = 23;
    localparam int FLG_LSB  = 24;
    localparam int SENT_POS = 31;

    typedef struct packed {
        logic [AUX_W-1:0]  aux;
        logic              berr;
        logic [CH_MAX-1:0] en;
        logic              men;
        logic [CH_MAX-1:0] flg;
        logic              sent;
    } ctl_t;

    function automatic logic [WORD_W-1:0] pack_word(input ctl_t s);
        logic [WORD_W-1:0] w;
        w = '0;
        w[AUX_W-1:0]                 = s.aux;
        w[BERR_POS]                  = s.berr;
        w[EN_LSB +: CH_MAX]          = s.en;
        w[MEN_POS]                   = s.men;
        w[FLG_LSB +: CH_MAX]         = s.flg;
        w[SENT_POS]                  = s.sent;
        return w;
    endfunction
endpackage

// File: rtl/irq_wr_merge.sv
module irq_wr_merge
    import dma_irq_pkg::*;
#(
    parameter int NUM_CH = CH_MAX
) (
    input  logic               wr_en,
    input  logic [WORD_W-1:0]  wr_data,
    input  ctl_t               cur_q,
    output logic [AUX_W-1:0]   aux_d,
    output logic               berr_d,
    output logic [CH_MAX-1:0]  en_d,
    output logic               men_d,
    output logic [CH_MAX-1:0]  clr_req
);
    localparam logic [CH_MAX-1:0] CH_MASK = CH_MAX'((1 << NUM_CH) - 1);

    always_comb begin
        aux_d   = cur_q.aux;
        berr_d  = cur_q.berr;
        en_d    = cur_q.en;
        men_d   = cur_q.men;
        clr_req = '0;
        if (wr_en) begin
            aux_d   = wr_data[AUX_W-1:0];
            berr_d  = wr_data[BERR_POS];
            en_d    = wr_data[EN_LSB +: CH_MAX] & CH_MASK;
            men_d   = wr_data[MEN_POS];
            clr_req = wr_data[FLG_LSB +: CH_MAX] & CH_MASK;
        end
    end
endmodule

// File: rtl/irq_flag_bank.sv
module irq_flag_bank
    import dma_irq_pkg::*;
#(
    parameter int NUM_CH = CH_MAX
) (
    input  logic [CH_MAX-1:0] flg_q,
    input  logic [CH_MAX-1:0] en_q,
    input  logic [CH_MAX-1:0] clr_req,
    input  logic [CH_MAX-1:0] done_stb,
    output logic [CH_MAX-1:0] flg_d
);
    for (genvar n = 0; n < CH_MAX; n++) begin : g_ch
        if (n < NUM_CH) begin : g_live
            // a completion wins over a same-cycle acknowledge
            always_comb flg_d[n] = (flg_q[n] & ~clr_req[n]) | (done_stb[n] & en_q[n]);
        end else begin : g_dead
            always_comb flg_d[n] = 1'b0;
        end
    end
endmodule

// File: rtl/irq_send_eval.sv
module irq_send_eval
    import dma_irq_pkg::*;
(
    input  logic              men_d,
    input  logic              berr_d,
    input  logic [CH_MAX-1:0] flg_d,
    input  logic              sent_q,
    output logic              cond_d,
    output logic              pulse_d
);
    always_comb begin
        cond_d  = (men_d && (|flg_d)) || berr_d;
        pulse_d = cond_d && !sent_q;
    end
endmodule

// File: rtl/dma_irq_ctl.sv
module dma_irq_ctl
    import dma_irq_pkg::*;
#(
    parameter int NUM_CH = CH_MAX
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [WORD_W-1:0]  wr_data,
    input  logic [CH_MAX-1:0]  done_stb,
    output logic [WORD_W-1:0]  rd_data,
    output logic               irq_pulse
);
    if (NUM_CH < 1 || NUM_CH > CH_MAX) begin : g_bad_cfg
        initial $error("NUM_CH out of range");
    end

    typedef struct packed {
        ctl_t ctl;
        logic pulse;
    } st_t;

    st_t state_d, state_q;

    logic [AUX_W-1:0]  aux_n;
    logic              berr_n;
    logic [CH_MAX-1:0] en_n;
    logic              men_n;
    logic [CH_MAX-1:0] clr_n;
    logic [CH_MAX-1:0] flg_n;
    logic              cond_n;
    logic              pulse_n;

    irq_wr_merge #(.NUM_CH(NUM_CH)) u_merge (
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .cur_q   (state_q.ctl),
        .aux_d   (aux_n),
        .berr_d  (berr_n),
        .en_d    (en_n),
        .men_d   (men_n),
        .clr_req (clr_n)
    );

    irq_flag_bank #(.NUM_CH(NUM_CH)) u_flags (
        .flg_q    (state_q.ctl.flg),
        .en_q     (state_q.ctl.en),
        .clr_req  (clr_n),
        .done_stb (done_stb),
        .flg_d    (flg_n)
    );

    irq_send_eval u_eval (
        .men_d   (men_n),
        .berr_d  (berr_n),
        .flg_d   (flg_n),
        .sent_q  (state_q.ctl.sent),
        .cond_d  (cond_n),
        .pulse_d (pulse_n)
    );

    always_comb begin
        state_d          = state_q;
        state_d.ctl.aux  = aux_n;
        state_d.ctl.berr = berr_n;
        state_d.ctl.en   = en_n;
        state_d.ctl.men  = men_n;
        state_d.ctl.flg  = flg_n;
        state_d.ctl.sent = cond_n;
        state_d.pulse    = pulse_n;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign rd_data   = pack_word(state_q.ctl);
    assign irq_pulse = state_q.pulse;

    // R6: a pulse only accompanies a 0 -> 1 change of bit 31
    a_r6_pulse_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
        irq_pulse |-> (rd_data[SENT_POS] && !$past(rd_data[SENT_POS])));
    a_r6_rise_has_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rd_data[SENT_POS]) |-> irq_pulse);
    // R8: never two pulse cycles back to back
    a_r8_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        irq_pulse |=> !irq_pulse);
    // R4: a flag never rises on a channel that was disabled
    a_r4_enable_gate: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q.ctl.flg & ~$past(state_q.ctl.flg) & ~$past(state_q.ctl.en)) == '0);
    // R3: a flag only falls after a write
    a_r3_clear_needs_write: assert property (@(posedge clk) disable iff (!rst_n)
        ((~state_q.ctl.flg & $past(state_q.ctl.flg)) != '0) |-> $past(wr_en));
    // R5: bit 31 agrees with the condition rebuilt from the stored fields
    a_r5_sent_matches: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[SENT_POS] == ((rd_data[MEN_POS] && (|rd_data[FLG_LSB +: CH_MAX])) || rd_data[BERR_POS]));
    // R2: bits 6 to 14 stay 0
    a_r2_gap_zero: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[BERR_POS-1:AUX_W] == '0);
endmodule

// File: tb/tb_dma_irq_ctl.sv
`timescale 1ns/1ps
module tb_dma_irq_ctl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic [6:0]  done_stb = '0;
    logic [31:0] rd_data;
    logic        irq_pulse;

    int total = 0;
    int bad = 0;

    always #2 clk = ~clk;

    dma_irq_ctl dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .done_stb(done_stb), .rd_data(rd_data), .irq_pulse(irq_pulse)
    );

    task automatic check(input string req, input logic [31:0] exp_w, input logic exp_p);
        total++;
        if (rd_data !== exp_w || irq_pulse !== exp_p) begin
            bad++;
            $display("FAIL %s: word=%08h pulse=%0b expected word=%08h pulse=%0b",
                     req, rd_data, irq_pulse, exp_w, exp_p);
        end
    endtask

    // one cycle of stimulus, then sample at the following falling edge
    task automatic cycle(input logic we, input logic [31:0] d, input logic [6:0] stb);
        wr_en = we; wr_data = d; done_stb = stb;
        @(negedge clk);
        wr_en = 1'b0; wr_data = '0; done_stb = '0;
    endtask

    task automatic t_reset;
        check("R1 reset", 32'h0000_0000, 1'b0);
    endtask

    task automatic t_mask;
        cycle(1'b1, 32'hFFFF_FFFF, '0);
        check("R2 mask with bus error", 32'h80FF_803F, 1'b1);
        cycle(1'b0, '0, '0);
        check("R8 pulse drops", 32'h80FF_803F, 1'b0);
        cycle(1'b1, 32'h0000_0000, '0);
        check("R5 bit31 clears on write", 32'h0000_0000, 1'b0);
        cycle(1'b1, 32'h8000_0000, '0);
        check("R2 bit31 write ignored", 32'h0000_0000, 1'b0);
    endtask

    task automatic t_strobe;
        cycle(1'b1, 32'h0081_0000, '0);
        check("R2 enables", 32'h0081_0000, 1'b0);
        cycle(1'b0, '0, 7'b0000010);
        check("R4 disabled channel ignored", 32'h0081_0000, 1'b0);
        cycle(1'b0, '0, 7'b0000001);
        check("R4 enabled channel flags", 32'h8181_0000, 1'b1);
        cycle(1'b0, '0, 7'b0000001);
        check("R6 no second pulse", 32'h8181_0000, 1'b0);
        cycle(1'b1, 32'h0081_0000, '0);
        check("R3 zero keeps flag", 32'h8181_0000, 1'b0);
        cycle(1'b1, 32'h0181_0000, '0);
        check("R3 one clears flag", 32'h0081_0000, 1'b0);
        cycle(1'b0, '0, 7'b0000001);
        check("R6 new pulse after clear", 32'h8181_0000, 1'b1);
    endtask

    task automatic t_same_cycle;
        cycle(1'b1, 32'h0181_0000, 7'b0000001);
        check("R7 strobe beats clear", 32'h8181_0000, 1'b0);
        cycle(1'b1, 32'h0181_0000, '0);
        check("R3 clear again", 32'h0081_0000, 1'b0);
        cycle(1'b1, 32'h0100_0000, 7'b0000001);
        check("R7 old enable gates", 32'h0100_0000, 1'b0);
        cycle(1'b1, 32'h0100_0000, '0);
        check("R3 final clear", 32'h0000_0000, 1'b0);
    endtask

    task automatic t_master_late;
        cycle(1'b1, 32'h0004_0000, '0);
        cycle(1'b0, '0, 7'b0000100);
        check("R5 flag without master", 32'h0404_0000, 1'b0);
        cycle(1'b1, 32'h0084_0000, '0);
        check("R5 master on raises", 32'h8484_0000, 1'b1);
        cycle(1'b1, 32'h0000_8000, '0);
        check("R6 stays set no pulse", 32'h8400_8000, 1'b0);
        cycle(1'b1, 32'h0400_0000, '0);
        check("R5 all false", 32'h0000_0000, 1'b0);
        cycle(1'b1, 32'h0000_8000, '0);
        check("R5 bus error alone", 32'h8000_8000, 1'b1);
    endtask

    initial begin
        fork
            begin
                repeat (3) @(negedge clk);
                rst_n = 1'b1;
                @(negedge clk);
                t_reset();
                t_mask();
                t_strobe();
                t_same_cycle();
                t_master_late();
            end
            begin
                repeat (5000) @(posedge clk);
                total++; bad++;
                $display("FAIL watchdog: expired expected completion");
            end
        join_any
        disable fork;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule